// File: doc/BRIEF.md
# Burst ROM Bus Cycle Generator

This block drives read cycles on an external 16-bit memory bus for one address area that can be set up to hold burst ROM. A CPU-side port presents a byte address, a flag that marks an instruction fetch, and a valid/ready handshake. The bus side drives the address, an active-low chip select and an active-low read strobe, samples the data bus, and takes a wait input. Each access returns the sampled word to the CPU as a one-cycle response pulse.

A run of sequential instruction fetches to area 0 (address bits [23:21] all zero) with burst mode on gets one full-length access and then short beats. The beats keep the select and strobe low and only change the low address bits inside an aligned block of 4 or 8 words. The full access is 2 or 3 states long, and only the 3-state form can be stretched by the wait input. Beats are 1 or 2 states and never wait. The CPU keeps its next request on the port while an access runs. The block accepts it in the final state of the current access only when it continues the burst. Any other request is taken after the select has gone high for one state.

The controller is a six-state machine. IDLE: bus released, `req_ready` high, a valid request moves to FULL1. FULL1 always moves to FULL2. FULL2 is the final state when `cfg_ast` is 0. Otherwise it stays in FULL2 while `ext_wait` is high and moves to FULL3 when it is low. FULL3 is always a final state. BEAT1 is the final state when `cfg_bspd` is 0 and moves to BEAT2 otherwise. BEAT2 is always a final state. From any final state the machine goes to BEAT1 when the burst continues and to IDLE when it does not.

Top module: `brom_bus_ctrl`

## Requirements
- R1: A full access holds `ext_cs_n` low for 2 states when `cfg_ast`=0 and 3 states when `cfg_ast`=1, starting the state after the request is accepted from idle.
- R2: With `cfg_ast`=1, each high sample of `ext_wait` in the second state of a full access adds one state. With `cfg_ast`=0, `ext_wait` has no effect.
- R3: Each burst beat after the full access lasts 1 state when `cfg_bspd`=0 and 2 states when `cfg_bspd`=1.
- R4: `ext_wait` is ignored during burst beats.
- R5: Data reads (`req_fetch`=0) always get full accesses and never start or continue a burst.
- R6: Bursts happen only when `cfg_brst_en`=1 and the address lies in area 0 (`req_addr[23:21]`=0). Otherwise every access is full-length.
- R7: A burst stays inside an aligned block of 4 words (`cfg_blen8`=0, address bits [2:1]) or 8 words (`cfg_blen8`=1, bits [3:1]). Crossing the block boundary starts a new full access.
- R8: A burst continues only when the next request is a fetch to the current address plus 2. Any other request gets a full access.
- R9: `ext_rd_n` equals `ext_cs_n`. Both stay low across all beats of one burst and go high for at least one state between separate accesses.
- R10: `rsp_valid` pulses for one cycle in the state after the final state of each access, and `rsp_data` holds the bus data sampled in that final state.
- R11: After reset `ext_cs_n` and `ext_rd_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R12: In the state after a request is accepted, `ext_addr` equals that request's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | 24 | Byte address of the requested word |
| req_fetch | input | 1 | 1 for instruction fetch, 0 for data read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 16 | Word read from the bus |
| cfg_brst_en | input | 1 | Burst ROM mode for area 0 |
| cfg_ast | input | 1 | Full access of 3 states with wait sampling |
| cfg_blen8 | input | 1 | Burst block of 8 words instead of 4 |
| cfg_bspd | input | 1 | Beat length of 2 states instead of 1 |
| ext_addr | output | 24 | External address bus |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_data_in | input | 16 | External data bus |
| ext_wait | input | 1 | Wait request, active high |

## Verification
The select falls one cycle after an accepting edge. It stays low for 2+ast+waits cycles for the full access and then 1+bspd cycles per beat, and each response pulse follows the final state of its access by one cycle. The bench drives requests on falling edges and checks `req_ready` just before the rising edge. A monitor on the falling edge counts select-low cycles, select falls and response pulses. Every scenario waits until the bus is idle and then compares these totals with sums computed from the configuration bits, so each expected value reflects every state the machine passes through.

// File: rtl/brom_pkg.sv
package brom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FULL1,
        ST_FULL2,
        ST_FULL3,
        ST_BEAT1,
        ST_BEAT2
    } brom_state_t;

endpackage

// File: rtl/brom_seq_check.sv
module brom_seq_check #(
    parameter int ADDR_W    = 24,
    parameter int AREA_LSB  = 21,
    parameter int SHORT_LG2 = 2,
    parameter int LONG_LG2  = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_fetch,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fetch,
    input  logic              cfg_brst_en,
    input  logic              cfg_blen8,
    output logic              cont_ok
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

    logic              in_area0;
    logic              short_end;
    logic              long_end;
    logic              blk_end;
    logic [ADDR_W-1:0] next_addr;

    // Area decode: when no area bits exist every address is area 0.
    generate
        if (AREA_LSB >= ADDR_W) begin : g_no_area
            assign in_area0 = 1'b1;
        end else begin : g_area
            assign in_area0 = (cur_addr[ADDR_W-1:AREA_LSB] == '0);
        end
    endgenerate

    assign short_end = &cur_addr[SHORT_LG2:1];
    assign long_end  = &cur_addr[LONG_LG2:1];
    assign blk_end   = cfg_blen8 ? long_end : short_end;
    assign next_addr = cur_addr + WORD_STEP;

    always_comb begin
        cont_ok = cfg_brst_en && in_area0 && cur_fetch && !blk_end &&
                  req_valid && req_fetch && (req_addr == next_addr);
    end

endmodule

// File: rtl/brom_fsm.sv
module brom_fsm
    import brom_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic cont_ok,
    input  logic cfg_ast,
    input  logic cfg_bspd,
    input  logic ext_wait,
    output logic req_ready,
    output logic load,
    output logic final_st,
    output logic bus_on
);
    brom_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = req_valid ? ST_FULL1 : ST_IDLE;
            ST_FULL1: state_nx = ST_FULL2;
            ST_FULL2: begin
                if (!cfg_ast)      state_nx = cont_ok ? ST_BEAT1 : ST_IDLE;
                else if (ext_wait) state_nx = ST_FULL2;
                else               state_nx = ST_FULL3;
            end
            ST_FULL3: state_nx = cont_ok ? ST_BEAT1 : ST_IDLE;
            ST_BEAT1: begin
                if (cfg_bspd) state_nx = ST_BEAT2;
                else          state_nx = cont_ok ? ST_BEAT1 : ST_IDLE;
            end
            ST_BEAT2: state_nx = cont_ok ? ST_BEAT1 : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        final_st = 1'b0;
        bus_on   = 1'b1;
        unique case (state)
            ST_IDLE:  bus_on   = 1'b0;
            ST_FULL1: final_st = 1'b0;
            ST_FULL2: final_st = !cfg_ast;
            ST_FULL3: final_st = 1'b1;
            ST_BEAT1: final_st = !cfg_bspd;
            ST_BEAT2: final_st = 1'b1;
            default:  bus_on   = 1'b0;
        endcase
        req_ready = !bus_on || (final_st && cont_ok);
        load      = req_valid && req_ready;
    end

endmodule

// File: rtl/brom_dpath.sv
module brom_dpath #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fetch,
    input  logic              capture,
    input  logic [DATA_W-1:0] ext_data_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_fetch,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_fetch <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (load) begin
                cur_addr  <= req_addr;
                cur_fetch <= req_fetch;
            end
            rsp_valid <= capture;
            if (capture) rsp_data <= ext_data_in;
        end
    end

endmodule

// File: rtl/brom_bus_ctrl.sv
module brom_bus_ctrl #(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int AREA_LSB = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_fetch,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              cfg_brst_en,
    input  logic              cfg_ast,
    input  logic              cfg_blen8,
    input  logic              cfg_bspd,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_cs_n,
    output logic              ext_rd_n,
    input  logic [DATA_W-1:0] ext_data_in,
    input  logic              ext_wait
);
    logic              cont_ok;
    logic              load;
    logic              final_st;
    logic              bus_on;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_fetch;

    brom_seq_check #(.ADDR_W(ADDR_W), .AREA_LSB(AREA_LSB)) u_seq (
        .cur_addr    (cur_addr),
        .cur_fetch   (cur_fetch),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_fetch   (req_fetch),
        .cfg_brst_en (cfg_brst_en),
        .cfg_blen8   (cfg_blen8),
        .cont_ok     (cont_ok)
    );

    brom_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cont_ok   (cont_ok),
        .cfg_ast   (cfg_ast),
        .cfg_bspd  (cfg_bspd),
        .ext_wait  (ext_wait),
        .req_ready (req_ready),
        .load      (load),
        .final_st  (final_st),
        .bus_on    (bus_on)
    );

    brom_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .req_addr    (req_addr),
        .req_fetch   (req_fetch),
        .capture     (final_st),
        .ext_data_in (ext_data_in),
        .cur_addr    (cur_addr),
        .cur_fetch   (cur_fetch),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    assign ext_addr = cur_addr;
    assign ext_cs_n = !bus_on;
    assign ext_rd_n = !bus_on;

endmodule

// File: rtl/brom_bus_sva.sv
module brom_bus_sva #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              cfg_ast,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_cs_n,
    input logic              ext_rd_n
);
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs_n |-> req_ready);

    p_start_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cs_n && req_valid) |=> !ext_cs_n);

    p_short_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ext_cs_n) && !cfg_ast) |-> ##2 rsp_valid);

    p_rsp_after_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!ext_cs_n));

    p_addr_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (ext_addr == $past(req_addr)));

    p_rd_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rd_n == ext_cs_n);

endmodule

bind brom_bus_ctrl brom_bus_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .cfg_ast   (cfg_ast),
    .ext_addr  (ext_addr),
    .ext_cs_n  (ext_cs_n),
    .ext_rd_n  (ext_rd_n)
);

// File: tb/sim_brom_bus_ctrl.sv
`timescale 1ns/1ps
module sim_brom_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_fetch = 1'b0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        cfg_brst_en = 1'b0, cfg_ast = 1'b0, cfg_blen8 = 1'b0, cfg_bspd = 1'b0;
    logic [23:0] ext_addr;
    logic        ext_cs_n, ext_rd_n;
    logic [15:0] ext_data_in;
    logic        ext_wait = 1'b0;

    int checks = 0, fails = 0;
    int cs_low = 0, falls = 0, rsps = 0, data_err = 0, rd_err = 0;
    logic prev_cs = 1'b1;
    logic [23:0] acc_addr [16];
    int acc_n = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign ext_data_in = ext_addr[15:0] ^ 16'h5A3C;

    brom_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_fetch(req_fetch), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .cfg_brst_en(cfg_brst_en), .cfg_ast(cfg_ast),
        .cfg_blen8(cfg_blen8), .cfg_bspd(cfg_bspd), .ext_addr(ext_addr),
        .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_data_in(ext_data_in),
        .ext_wait(ext_wait)
    );

    // Bus monitor, sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ext_cs_n) cs_low++;
            if (!ext_cs_n && prev_cs) falls++;
            if (ext_rd_n != ext_cs_n) rd_err++;
            if (rsp_valid) begin
                if (rsps >= acc_n || rsp_data != (acc_addr[rsps][15:0] ^ 16'h5A3C))
                    data_err++;
                rsps++;
            end
        end
        prev_cs = ext_cs_n;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_seq(input string tag, input bit en, input bit ast, input bit b8,
                           input bit spd, input logic [23:0] start, input int n,
                           input bit fetch, input int jump_at, input int jump_off,
                           input int w, input bit hold, input int exp_cs, input int exp_falls);
        @(negedge clk);
        cfg_brst_en = en; cfg_ast = ast; cfg_blen8 = b8; cfg_bspd = spd;
        cs_low = 0; falls = 0; rsps = 0; data_err = 0; rd_err = 0; acc_n = 0;
        ext_wait = hold || (w > 0);
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            req_valid = 1'b1;
            req_fetch = fetch;
            req_addr  = start + 24'(2 * i) + ((i >= jump_at) ? 24'(jump_off) : 24'd0);
            forever begin
                #1;
                if (req_ready) break;
                @(negedge clk);
            end
            acc_addr[acc_n] = req_addr;
            acc_n++;
            @(posedge clk);
            if (i == 0 && w > 0 && !hold) begin
                fork
                    begin
                        repeat (w + 1) @(posedge clk);
                        #1 ext_wait = 1'b0;
                    end
                join_none
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        repeat (16) @(negedge clk);
        ext_wait = 1'b0;
        chk(cs_low == exp_cs, tag, "select-low states", cs_low, exp_cs);
        chk(falls == exp_falls, tag, "separate accesses", falls, exp_falls);
        chk(rsps == n, "R10", "response pulses", rsps, n);
        chk(data_err == 0, "R10/R12", "response data vs address", data_err, 0);
        chk(rd_err == 0, "R9", "strobe follows select", rd_err, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(ext_cs_n == 1'b1, "R11", "cs_n after reset", ext_cs_n, 1);
        chk(ext_rd_n == 1'b1, "R11", "rd_n after reset", ext_rd_n, 1);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", rsp_valid, 0);
        chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        // tag en ast b8 spd start n fetch jump_at off w hold cs falls
        run_seq("R1",  1, 0, 0, 0, 24'h000100, 1, 1, 99, 0, 0, 0, 2, 1);
        run_seq("R1",  1, 1, 0, 0, 24'h000100, 1, 1, 99, 0, 0, 0, 3, 1);
        run_seq("R2",  1, 1, 0, 0, 24'h000100, 1, 1, 99, 0, 2, 0, 5, 1);
        run_seq("R2",  1, 0, 0, 0, 24'h000100, 1, 1, 99, 0, 0, 1, 2, 1);
        run_seq("R3",  1, 0, 0, 0, 24'h000100, 4, 1, 99, 0, 0, 0, 5, 1);
        run_seq("R3",  1, 1, 0, 1, 24'h000100, 4, 1, 99, 0, 0, 0, 9, 1);
        run_seq("R4",  1, 0, 0, 1, 24'h000100, 4, 1, 99, 0, 0, 1, 8, 1);
        run_seq("R2",  1, 1, 0, 0, 24'h000100, 4, 1, 99, 0, 1, 0, 7, 1);
        run_seq("R5",  1, 0, 0, 0, 24'h000100, 3, 0, 99, 0, 0, 0, 6, 3);
        run_seq("R6",  0, 0, 0, 0, 24'h000100, 3, 1, 99, 0, 0, 0, 6, 3);
        run_seq("R6",  1, 0, 0, 0, 24'h200100, 2, 1, 99, 0, 0, 0, 4, 2);
        run_seq("R7",  1, 0, 1, 0, 24'h000110, 8, 1, 99, 0, 0, 0, 9, 1);
        run_seq("R7",  1, 0, 0, 0, 24'h000110, 8, 1, 99, 0, 0, 0, 10, 2);
        run_seq("R7",  1, 0, 0, 0, 24'h000104, 4, 1, 99, 0, 0, 0, 6, 2);
        run_seq("R8",  1, 0, 1, 0, 24'h000120, 3, 1, 2, 4, 0, 0, 5, 2);
        run_seq("R9",  1, 0, 0, 1, 24'h000140, 2, 0, 99, 0, 0, 0, 4, 2);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule